// File: doc/BRIEF.md
# Sprite Attribute Memory Access Port

This block is the processor-side register window into a 544-byte sprite attribute store. The store is split into a 512-byte main table and a 32-byte extension table. A 10-bit byte address walks the two tables. Its upper half, where address bit 9 is set, reaches the extension table, which repeats every 32 bytes. Software sets a 9-bit base, then streams bytes through a single data register. The address steps by one after every data access.

Writes to the main table are made as whole byte pairs. The even byte is held in a latch, and the pair is stored when the odd byte arrives. Extension-table bytes are stored at once. The block also gives the sprite engine a first-sprite index. When priority rotation is enabled, the index follows the byte address; otherwise it is zero. At the start of vertical blank, during forced blank, the byte address returns to the base.

Top module: `sprite_attr_port`

## Requirements
- R1: A write to register 0 (base low) sets base bits 7:0. A write to register 1 (base high) sets base bit 8 from data bit 0. Either write loads the byte address with the base shifted left by one.
- R2: A write to register 1 also stores data bit 7 as the rotation enable. While the enable is set, `first_idx` equals byte-address bits 8:2; otherwise it is 0. It tracks every address change.
- R3: A data write (register 2) at an even address with bit 9 clear stores the byte in the pair latch and leaves the main table unchanged.
- R4: A data write at an odd address with bit 9 clear stores the latched byte at the even partner address and the new byte at the odd address.
- R5: A data write with address bit 9 set stores the byte into the extension table at once, whatever the address parity.
- R6: Every data write or data read increments the byte address, wrapping from 0x3FF to 0x000.
- R7: A data read (`rd_en` with register 2) presents the byte at the current address on `rd_data` one clock later.
- R8: On a cycle with no register access, if `line_start` is high, `force_blank` is high, and `vcount` equals VB_LINE (or VB_LINE_TALL while `tall` is high), the byte address reloads from the base. Without forced blank or on another line it is unchanged.
- R9: With address bit 9 set, only address bits 4:0 select an extension-table byte, so every 32-byte window of the upper half aliases the same 32 bytes.
- R10: After reset the byte address, base, latch and rotation enable are zero, and `first_idx` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe (takes precedence over rd_en) |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 base low, 1 base high, 2 data, 3 unused |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after a data read |
| force_blank | input | 1 | Display forced blank |
| tall | input | 1 | Selects the taller frame's blank line |
| vcount | input | VC_W | Current vertical line |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| first_idx | output | 7 | First-sprite index for the sprite engine |

## Verification
The bench builds the block with the default lines, 225 and 240, and drives `vcount` to both. It also drives the non-matching line of each mode, so the line select for both frame heights is exercised. The 10-bit address space is small enough to cover the main table, the extension table at aliased offsets, and the wrap from the top of the extension table back to main-table byte 0.

// File: rtl/sprite_attr_port.sv
module sprite_attr_port #(
  parameter int VC_W = 9,
  parameter int VB_LINE = 225,
  parameter int VB_LINE_TALL = 240
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      reg_sel,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic            force_blank,
  input  logic            tall,
  input  logic [VC_W-1:0] vcount,
  input  logic            line_start,
  output logic [6:0]      first_idx
);
  localparam int AW = 10;
  localparam int LO_BYTES = 1 << (AW - 1);
  localparam int HI_W = 5;
  localparam int HI_BYTES = 1 << HI_W;

  logic [7:0] lo_tab [LO_BYTES];
  logic [7:0] hi_tab [HI_BYTES];
  logic [AW-1:0] addr;
  logic [8:0] base;
  logic [7:0] pair_latch;
  logic rot_en;

  wire blo_wr = wr_en && reg_sel == 2'd0;
  wire bhi_wr = wr_en && reg_sel == 2'd1;
  wire dat_wr = wr_en && reg_sel == 2'd2;
  wire dat_rd = !wr_en && rd_en && reg_sel == 2'd2;
  wire idle = !wr_en && !rd_en;
  wire [VC_W-1:0] blank_line = tall ? VC_W'(VB_LINE_TALL) : VC_W'(VB_LINE);
  wire reload = idle && line_start && force_blank && vcount == blank_line;

  assign first_idx = rot_en ? addr[8:2] : 7'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      base <= '0;
      pair_latch <= '0;
      rot_en <= 1'b0;
    end else if (blo_wr) begin
      base[7:0] <= wr_data;
      addr <= {base[8], wr_data, 1'b0};
    end else if (bhi_wr) begin
      base[8] <= wr_data[0];
      rot_en <= wr_data[7];
      addr <= {wr_data[0], base[7:0], 1'b0};
    end else if (dat_wr || dat_rd) begin
      if (dat_wr && !addr[0]) pair_latch <= wr_data;
      addr <= addr + 1'b1;
    end else if (reload) begin
      addr <= {base, 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (dat_wr) begin
      if (addr[AW-1]) begin
        hi_tab[addr[HI_W-1:0]] <= wr_data;
      end else if (addr[0]) begin
        lo_tab[{addr[8:1], 1'b0}] <= pair_latch;
        lo_tab[addr[8:0]] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (dat_rd) rd_data <= addr[AW-1] ? hi_tab[addr[HI_W-1:0]] : lo_tab[addr[8:0]];
  end

  a_r1_base_low: assert property (@(posedge clk) disable iff (!rst_n)
    blo_wr |=> addr == {$past(base[8]), $past(wr_data), 1'b0});
  a_r1_base_high: assert property (@(posedge clk) disable iff (!rst_n)
    bhi_wr |=> addr[9] == $past(wr_data[0]) && addr[0] == 1'b0);
  a_r2_idx_needs_rot: assert property (@(posedge clk) disable iff (!rst_n)
    first_idx != 7'd0 |-> rot_en);
  a_r3_even_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !addr[0]) |=> pair_latch == $past(wr_data));
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr || dat_rd) |=> addr == $past(addr) + 1'b1);
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> addr == {$past(base), 1'b0});
  a_r8_no_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !force_blank) |=> $stable(addr));
endmodule

// File: tb/sim_sprite_attr_port.sv
`timescale 1ns/1ps
module sim_sprite_attr_port;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic force_blank = 0, tall = 0, line_start = 0;
  logic [8:0] vcount = 0;
  logic [6:0] first_idx;

  sprite_attr_port u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data), .force_blank(force_blank),
    .tall(tall), .vcount(vcount), .line_start(line_start), .first_idx(first_idx));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [9:0] m_addr = 0;
  logic [8:0] m_base = 0;
  logic m_rot = 0;
  logic [7:0] m_latch = 0;
  logic [7:0] mlo [512];
  logic [7:0] mhi [32];
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic pend = 0;

  always @(posedge clk) pend <= rst_n && rd_en && !wr_en && reg_sel == 2'd2;

  always @(negedge clk) begin
    if (pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rd_data !== e) begin
        n_bad++;
        $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic check(string t, logic [7:0] act, logic [7:0] ex);
    n_chk++;
    if (act !== ex) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, ex);
    end
  endtask

  task automatic chk_idx(string t);
    check(t, {1'b0, first_idx}, {1'b0, m_rot ? m_addr[8:2] : 7'd0});
  endtask

  task automatic pulse(logic w, logic r, logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; reg_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic set_lo(logic [7:0] d);
    m_base[7:0] = d; m_addr = {m_base, 1'b0};
    pulse(1, 0, 2'd0, d);
  endtask

  task automatic set_hi(logic [7:0] d);
    m_base[8] = d[0]; m_rot = d[7]; m_addr = {m_base, 1'b0};
    pulse(1, 0, 2'd1, d);
  endtask

  task automatic dwrite(logic [7:0] d);
    if (m_addr[9]) mhi[m_addr[4:0]] = d;
    else if (!m_addr[0]) m_latch = d;
    else begin mlo[{m_addr[8:1], 1'b0}] = m_latch; mlo[m_addr[8:0]] = d; end
    m_addr = m_addr + 1;
    pulse(1, 0, 2'd2, d);
  endtask

  task automatic dread(string t);
    exp_q.push_back(m_addr[9] ? mhi[m_addr[4:0]] : mlo[m_addr[8:0]]);
    tag_q.push_back(t);
    m_addr = m_addr + 1;
    pulse(0, 1, 2'd2, 8'h00);
  endtask

  task automatic vb(logic b, logic tl, logic [8:0] v);
    @(negedge clk);
    force_blank = b; tall = tl; vcount = v; line_start = 1;
    @(negedge clk);
    line_start = 0; force_blank = 0;
    if (b && v == (tl ? 9'd240 : 9'd225)) m_addr = {m_base, 1'b0};
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 idx", {1'b0, first_idx}, 8'h00);
    check("R10 rd_data", rd_data, 8'h00);
    // R4 pair commits, R7 read latency
    set_lo(8'h00); set_hi(8'h00);
    dwrite(8'hAA); dwrite(8'hBB); dwrite(8'h11); dwrite(8'h22);
    set_lo(8'h00);
    dread("R4"); dread("R4"); dread("R7"); dread("R7");
    // R3 lone even write leaves table intact
    set_lo(8'h00); dwrite(8'hCC);
    set_lo(8'h00); dread("R3"); dread("R3");
    // R5 extension table direct write
    set_hi(8'h01); set_lo(8'h00);
    dwrite(8'h5A); dwrite(8'hA5);
    set_lo(8'h00); dread("R5"); dread("R5");
    // R9 aliasing, R6 wrap
    set_lo(8'h10); dread("R9 alias");
    set_lo(8'hFF); dwrite(8'h77); dwrite(8'h88);
    check("R6 wrap idx", {1'b0, first_idx}, 8'h00);
    dread("R6 wrap");
    set_lo(8'h0F); dread("R9 alias30"); dread("R9 alias31");
    // R2 rotation index
    set_hi(8'h80); chk_idx("R2 base0F");
    set_lo(8'h20); chk_idx("R2 base20");
    for (int i = 0; i < 8; i++) begin dwrite(8'(i * 19 + 1)); chk_idx("R2 wr"); end
    set_lo(8'h20);
    for (int i = 0; i < 8; i++) begin dread("R2 rd"); chk_idx("R2 rd"); end
    vb(1, 0, 9'd225); chk_idx("R8 reload idx");
    set_hi(8'h00); chk_idx("R2 off");
    // R8 reload conditions
    set_lo(8'h20); dread("R8"); dread("R8");
    vb(0, 0, 9'd225); dread("R8 no blank");
    vb(1, 0, 9'd240); dread("R8 wrong line");
    vb(1, 0, 9'd225); dread("R8 short frame");
    dread("R8");
    vb(1, 1, 9'd225); dread("R8 tall wrong line");
    vb(1, 1, 9'd240); dread("R8 tall frame");
    repeat (3) @(negedge clk);
    check("queue drained", 8'(exp_q.size()), 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule